// File: doc/BRIEF.md
# Dual-Buffer Frame Transmit Register Block

This block is the transmit half of a small Ethernet MAC as software sees it. A processor reaches it over a 32-bit slave bus with word addresses. The address space holds two equal transmit buffers. At the top of each buffer sit a byte-count word and a command word, and one word in the first buffer carries the global interrupt enable. Software fills a buffer with frame bytes in big-endian word order, writes the byte count, and then writes a command word. The command either streams the frame out one byte at a time on a valid/ready/last port, or loads a 48-bit station address from the first six bytes of the buffer.

A command marks its buffer busy until it completes. When it completes, the block may raise a one-cycle interrupt, but only if the buffer's own enable and the global enable are both set. Preamble, frame check sequence, the PHY side and reception belong to other blocks.

Top module: `eth_tx_regif`

## Requirements
- R1: After reset `tx_valid`, `tx_last` and `irq` are low, `station_addr` is zero, and every length, command and global-enable word reads 0.
- R2: A read returns its data on `bus_rdata` one cycle after the bus cycle and holds it until the next read. Buffer b (0 or 1) occupies word addresses b*512 to b*512+511. Word 509 of a buffer is its length, word 511 is its command, and word 510 of buffer 0 is the global enable. Every other word is frame storage. All of these read back what was last written.
- R3: A command with bit 0 = 1 and bit 1 = 0 sends the buffer. The block streams the byte count of bytes in frame order. Frame byte i is bits [31-8*(i%4) -: 8] of buffer word i/4.
- R4: A byte is accepted on a clock where `tx_valid` and `tx_ready` are both high. `tx_last` is high only with the final byte. While `tx_ready` is low, `tx_data` and `tx_last` hold steady.
- R5: A command with bit 0 = 1 and bit 1 = 1 loads `station_addr` with byte 0 in bits 47:40 through byte 5 in bits 7:0. It sends nothing.
- R6: While a command is pending or running, its command word reads back bits 1:0 as written. On completion those two bits clear and the other bits, including the interrupt enable (bit 3), are kept.
- R7: A write to the command word of a busy buffer has no effect. This includes a write in the clock where that buffer completes.
- R8: The byte count is clamped to 2036. A count of 0 completes without asserting `tx_valid`.
- R9: On completion `irq` is high for one cycle if and only if the buffer's bit 3 and bit 31 of the global enable word are both set.
- R10: A command write with bit 0 = 0 starts nothing. It stores the word with bits 1:0 cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_en | input | 1 | Bus cycle request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 10 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the read |
| tx_data | output | 8 | Frame byte |
| tx_valid | output | 1 | Byte available |
| tx_ready | input | 1 | Downstream accepts the byte |
| tx_last | output | 1 | Final byte of the frame |
| station_addr | output | 48 | Station address loaded by the program command |
| irq | output | 1 | One-cycle completion interrupt |

## Verification
Two things can land on the same clock: a buffer finishing its final byte and a new command write. The bench stalls `tx_ready` on the last byte of buffer 0. It then raises `tx_ready` in the very clock in which it writes a start command, once to buffer 1 and once to buffer 0. The write to buffer 1 must be accepted and served right after buffer 0 ends, with one interrupt for each buffer. The write to buffer 0 must vanish, which the bench judges from its read-back value and the absence of a further byte stream.

// File: rtl/eth_txr_pkg.sv
package eth_txr_pkg;

  localparam int CMD_START = 0;
  localparam int CMD_PROG  = 1;
  localparam int CMD_IEN   = 3;
  localparam int GIE_BIT   = 31;

  typedef enum logic [0:0] {ENG_IDLE, ENG_SEND} eng_state_t;

  // Byte lane of a big-endian word: lane 0 is the most significant byte.
  function automatic logic [7:0] be_byte(input logic [31:0] w, input logic [1:0] lane);
    return w[8*(3-lane) +: 8];
  endfunction

  // Effective byte count of a frame.
  function automatic logic [31:0] clamp_len(input logic [31:0] len, input logic [31:0] cap);
    return (len > cap) ? cap : len;
  endfunction

  // Value kept in a command word after a write that is accepted.
  function automatic logic [31:0] cmd_store(input logic [31:0] w);
    return w[CMD_START] ? w : {w[31:2], 2'b00};
  endfunction

endpackage

// File: rtl/txr_regs.sv
module txr_regs
  import eth_txr_pkg::*;
#(
  parameter int NUM_BUFS = 2,
  parameter int BUF_AW   = 9,
  localparam int IDX_W   = $clog2(NUM_BUFS),
  localparam int ADDR_W  = IDX_W + BUF_AW
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          bus_en,
  input  logic                          bus_we,
  input  logic [ADDR_W-1:0]             bus_addr,
  input  logic [31:0]                   bus_wdata,
  output logic [31:0]                   bus_rdata,
  output logic [NUM_BUFS-1:0][31:0]     ctrl_q,
  output logic [NUM_BUFS-1:0][31:0]     len_q,
  output logic                          gie_en,
  input  logic [NUM_BUFS-1:0]           done_vec,
  input  logic [ADDR_W-1:0]             rd_addr_a,
  input  logic [ADDR_W-1:0]             rd_addr_b,
  output logic [31:0]                   rd_word_a,
  output logic [15:0]                   rd_half_b
);
  localparam int BUF_WORDS = 1 << BUF_AW;
  localparam int MEM_WORDS = NUM_BUFS * BUF_WORDS;
  localparam logic [BUF_AW-1:0] OFF_LEN  = BUF_AW'(BUF_WORDS - 3);
  localparam logic [BUF_AW-1:0] OFF_GIE  = BUF_AW'(BUF_WORDS - 2);
  localparam logic [BUF_AW-1:0] OFF_CTRL = BUF_AW'(BUF_WORDS - 1);

  logic [31:0] mem [MEM_WORDS];
  logic [31:0] gie_q;

  logic [IDX_W-1:0]  w_buf;
  logic [BUF_AW-1:0] w_off;
  logic is_len, is_ctrl, is_gie, is_data, wr_ev, rd_ev;

  assign w_buf   = bus_addr[ADDR_W-1:BUF_AW];
  assign w_off   = bus_addr[BUF_AW-1:0];
  assign is_len  = (w_off == OFF_LEN);
  assign is_ctrl = (w_off == OFF_CTRL);
  assign is_gie  = (w_off == OFF_GIE) && (w_buf == '0);
  assign is_data = !is_len && !is_ctrl && !is_gie;
  assign wr_ev   = bus_en && bus_we;
  assign rd_ev   = bus_en && !bus_we;

  always_ff @(posedge clk) begin
    if (wr_ev && is_data) mem[bus_addr] <= bus_wdata;
  end

  logic [31:0] rd_word_b;
  assign rd_word_a = mem[rd_addr_a];
  assign rd_word_b = mem[rd_addr_b];
  assign rd_half_b = rd_word_b[31:16];

  for (genvar b = 0; b < NUM_BUFS; b++) begin : g_buf
    logic sel_b;
    assign sel_b = (w_buf == IDX_W'(b));
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ctrl_q[b] <= '0;
        len_q[b]  <= '0;
      end else begin
        if (wr_ev && sel_b && is_len) len_q[b] <= bus_wdata;
        if (done_vec[b]) ctrl_q[b][1:0] <= 2'b00;
        else if (wr_ev && sel_b && is_ctrl && !ctrl_q[b][CMD_START])
          ctrl_q[b] <= cmd_store(bus_wdata);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) gie_q <= '0;
    else if (wr_ev && is_gie) gie_q <= bus_wdata;
  end
  assign gie_en = gie_q[GIE_BIT];

  logic [31:0] rd_val;
  always_comb begin
    if (is_len)       rd_val = len_q[w_buf];
    else if (is_ctrl) rd_val = ctrl_q[w_buf];
    else if (is_gie)  rd_val = gie_q;
    else              rd_val = mem[bus_addr];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     bus_rdata <= '0;
    else if (rd_ev) bus_rdata <= rd_val;
  end

endmodule

// File: rtl/txr_pick.sv
module txr_pick #(
  parameter int NUM_BUFS = 2,
  localparam int IDX_W   = $clog2(NUM_BUFS)
) (
  input  logic [NUM_BUFS-1:0] pend,
  output logic                pick_valid,
  output logic [IDX_W-1:0]    pick_idx
);
  // Fixed order: the lowest-numbered pending buffer wins.
  always_comb begin
    pick_valid = 1'b0;
    pick_idx   = '0;
    for (int b = NUM_BUFS - 1; b >= 0; b--) begin
      if (pend[b]) begin
        pick_valid = 1'b1;
        pick_idx   = IDX_W'(b);
      end
    end
  end
endmodule

// File: rtl/txr_engine.sv
module txr_engine
  import eth_txr_pkg::*;
#(
  parameter int          NUM_BUFS     = 2,
  parameter int          BUF_AW       = 9,
  parameter logic [47:0] STATION_INIT = 48'h0,
  localparam int IDX_W     = $clog2(NUM_BUFS),
  localparam int ADDR_W    = IDX_W + BUF_AW,
  localparam int CAP_BYTES = ((1 << BUF_AW) - 3) * 4,
  localparam int CNT_W     = $clog2(CAP_BYTES + 1)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      pick_valid,
  input  logic [IDX_W-1:0]          pick_idx,
  input  logic [NUM_BUFS-1:0]       prog_vec,
  input  logic [NUM_BUFS-1:0]       ien_vec,
  input  logic [NUM_BUFS-1:0][31:0] len_q,
  input  logic                      gie_en,
  output logic [ADDR_W-1:0]         rd_addr_a,
  output logic [ADDR_W-1:0]         rd_addr_b,
  input  logic [31:0]               rd_word_a,
  input  logic [15:0]               rd_half_b,
  output logic [NUM_BUFS-1:0]       done_vec,
  output logic                      done_evt,
  output logic                      done_prog,
  output logic [7:0]                tx_data,
  output logic                      tx_valid,
  input  logic                      tx_ready,
  output logic                      tx_last,
  output logic [47:0]               station_addr,
  output logic                      irq
);
  eng_state_t       state;
  logic [IDX_W-1:0] sel;
  logic [CNT_W-1:0] idx, len_lat;

  logic             pick_prog, start_evt, hs, fin_send;
  logic [31:0]      pick_len32;
  logic [CNT_W-1:0] pick_len;
  logic [IDX_W-1:0] done_buf;
  logic [BUF_AW-1:0] word_off;

  assign pick_prog  = prog_vec[pick_idx];
  assign pick_len32 = clamp_len(len_q[pick_idx], 32'(CAP_BYTES));
  assign pick_len   = pick_len32[CNT_W-1:0];
  assign start_evt  = (state == ENG_IDLE) && pick_valid;
  assign hs         = (state == ENG_SEND) && tx_ready;
  assign fin_send   = hs && (idx == len_lat - CNT_W'(1));
  assign done_evt   = (start_evt && (pick_prog || pick_len == '0)) || fin_send;
  assign done_prog  = start_evt && pick_prog;
  assign done_buf   = (state == ENG_IDLE) ? pick_idx : sel;

  always_comb begin
    for (int b = 0; b < NUM_BUFS; b++)
      done_vec[b] = done_evt && (done_buf == IDX_W'(b));
  end

  assign word_off  = BUF_AW'(idx >> 2);
  assign rd_addr_a = (state == ENG_IDLE) ? {pick_idx, BUF_AW'(0)} : {sel, word_off};
  assign rd_addr_b = {pick_idx, BUF_AW'(1)};

  assign tx_valid = (state == ENG_SEND);
  assign tx_data  = be_byte(rd_word_a, idx[1:0]);
  assign tx_last  = tx_valid && (idx == len_lat - CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state        <= ENG_IDLE;
      sel          <= '0;
      idx          <= '0;
      len_lat      <= '0;
      station_addr <= STATION_INIT;
      irq          <= 1'b0;
    end else begin
      irq <= done_evt && ien_vec[done_buf] && gie_en;
      if (done_prog) station_addr <= {rd_word_a, rd_half_b};
      unique case (state)
        ENG_IDLE: begin
          if (start_evt && !pick_prog && pick_len != '0) begin
            state   <= ENG_SEND;
            sel     <= pick_idx;
            idx     <= '0;
            len_lat <= pick_len;
          end
        end
        ENG_SEND: begin
          if (fin_send)  state <= ENG_IDLE;
          else if (hs)   idx   <= idx + CNT_W'(1);
        end
        default: state <= ENG_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/eth_tx_regif.sv
module eth_tx_regif
  import eth_txr_pkg::*;
#(
  parameter int          NUM_BUFS     = 2,
  parameter int          BUF_AW       = 9,
  parameter logic [47:0] STATION_INIT = 48'h0,
  localparam int IDX_W  = $clog2(NUM_BUFS),
  localparam int ADDR_W = IDX_W + BUF_AW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic [7:0]        tx_data,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic              tx_last,
  output logic [47:0]       station_addr,
  output logic              irq
);
  logic [NUM_BUFS-1:0][31:0] ctrl_q, len_q;
  logic [NUM_BUFS-1:0]       pend_vec, prog_vec, ien_vec, done_vec;
  logic                      gie_en, pick_valid, done_evt, done_prog;
  logic [IDX_W-1:0]          pick_idx;
  logic [ADDR_W-1:0]         rd_addr_a, rd_addr_b;
  logic [31:0]               rd_word_a;
  logic [15:0]               rd_half_b;

  for (genvar b = 0; b < NUM_BUFS; b++) begin : g_bits
    assign pend_vec[b] = ctrl_q[b][CMD_START];
    assign prog_vec[b] = ctrl_q[b][CMD_PROG];
    assign ien_vec[b]  = ctrl_q[b][CMD_IEN];
  end

  txr_regs #(.NUM_BUFS(NUM_BUFS), .BUF_AW(BUF_AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ctrl_q(ctrl_q), .len_q(len_q), .gie_en(gie_en), .done_vec(done_vec),
    .rd_addr_a(rd_addr_a), .rd_addr_b(rd_addr_b),
    .rd_word_a(rd_word_a), .rd_half_b(rd_half_b)
  );

  txr_pick #(.NUM_BUFS(NUM_BUFS)) u_pick (
    .pend(pend_vec), .pick_valid(pick_valid), .pick_idx(pick_idx)
  );

  txr_engine #(.NUM_BUFS(NUM_BUFS), .BUF_AW(BUF_AW), .STATION_INIT(STATION_INIT)) u_eng (
    .clk(clk), .rst_n(rst_n), .pick_valid(pick_valid), .pick_idx(pick_idx),
    .prog_vec(prog_vec), .ien_vec(ien_vec), .len_q(len_q), .gie_en(gie_en),
    .rd_addr_a(rd_addr_a), .rd_addr_b(rd_addr_b),
    .rd_word_a(rd_word_a), .rd_half_b(rd_half_b),
    .done_vec(done_vec), .done_evt(done_evt), .done_prog(done_prog),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_last(tx_last),
    .station_addr(station_addr), .irq(irq)
  );
endmodule

// File: rtl/eth_tx_regif_chk.sv
module eth_tx_regif_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [7:0]  tx_data,
  input logic        tx_valid,
  input logic        tx_ready,
  input logic        tx_last,
  input logic [47:0] station_addr,
  input logic        irq,
  input logic        done_evt,
  input logic        done_prog
);
  AST_LAST_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    tx_last |-> tx_valid); // R4

  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_last))); // R4

  AST_VALID_ENDS_ON_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_valid) |-> $past(tx_last && tx_ready)); // R3

  AST_IRQ_FOLLOWS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(done_evt)); // R9

  AST_PROG_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    done_prog |-> !tx_valid); // R5

  AST_STATION_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(done_prog) |-> $stable(station_addr)); // R5
endmodule

bind eth_tx_regif eth_tx_regif_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tx_data(tx_data), .tx_valid(tx_valid),
  .tx_ready(tx_ready), .tx_last(tx_last), .station_addr(station_addr),
  .irq(irq), .done_evt(done_evt), .done_prog(done_prog)
);

// File: tb/tb_eth_tx_regif.sv
`timescale 1ns/1ps
module tb_eth_tx_regif;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_en = 1'b0, bus_we = 1'b0, tx_ready = 1'b0;
  logic [9:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [7:0]  tx_data;
  logic        tx_valid, tx_last, irq;
  logic [47:0] station_addr;

  always #2.5 clk = ~clk;

  eth_tx_regif dut (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_last(tx_last), .station_addr(station_addr), .irq(irq)
  );

  int total = 0, bad = 0, cyc = 0, n_hs = 0, n_irq = 0;
  bit cmp_on = 0;

  // Behavioural reference model
  int          m_mem [1024];
  logic [31:0] m_len [2];
  logic [31:0] m_ctrl [2];
  logic [31:0] m_gie, m_rdata;
  logic [47:0] m_station;
  int          m_state, m_sel, m_idx, m_L;
  bit          m_irq;

  function automatic int clampm(logic [31:0] l);
    return (l > 32'd2036) ? 2036 : int'(l);
  endfunction
  function automatic logic [7:0] byte_at(int b, int i);
    logic [31:0] w;
    w = m_mem[b*512 + i/4];
    return w[31 - 8*(i%4) -: 8];
  endfunction
  function automatic logic [31:0] m_read(logic [9:0] a);
    int b, o;
    b = a[9]; o = a[8:0];
    if (o == 509) return m_len[b];
    if (o == 511) return m_ctrl[b];
    if (o == 510 && b == 0) return m_gie;
    return m_mem[a];
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (tx_valid && tx_ready) n_hs++;
    if (irq) n_irq++;
    if (!rst_n) begin
      for (int i = 0; i < 2; i++) begin m_len[i] = 0; m_ctrl[i] = 0; end
      m_gie = 0; m_rdata = 0; m_station = 0; m_state = 0; m_sel = 0;
      m_idx = 0; m_L = 0; m_irq = 0;
    end else begin
      bit done; int db; int pk; bit busy [2];
      done = 0; db = 0;
      busy[0] = m_ctrl[0][0]; busy[1] = m_ctrl[1][0];
      if (bus_en && !bus_we) m_rdata = m_read(bus_addr);
      if (m_state == 0) begin
        pk = busy[0] ? 0 : (busy[1] ? 1 : -1);
        if (pk >= 0) begin
          if (m_ctrl[pk][1]) begin
            m_station = {byte_at(pk,0), byte_at(pk,1), byte_at(pk,2),
                         byte_at(pk,3), byte_at(pk,4), byte_at(pk,5)};
            done = 1; db = pk;
          end else if (clampm(m_len[pk]) == 0) begin
            done = 1; db = pk;
          end else begin
            m_state = 1; m_sel = pk; m_idx = 0; m_L = clampm(m_len[pk]);
          end
        end
      end else if (tx_ready) begin
        if (m_idx == m_L - 1) begin done = 1; db = m_sel; m_state = 0; end
        else m_idx++;
      end
      m_irq = done && m_ctrl[db][3] && m_gie[31];
      if (done) m_ctrl[db][1:0] = 2'b00;
      if (bus_en && bus_we) begin
        int b, o;
        b = bus_addr[9]; o = bus_addr[8:0];
        if (o == 509) m_len[b] = bus_wdata;
        else if (o == 511) begin
          if (!busy[b]) m_ctrl[b] = bus_wdata[0] ? bus_wdata : {bus_wdata[31:2], 2'b00};
        end else if (o == 510 && b == 0) m_gie = bus_wdata;
        else m_mem[bus_addr] = bus_wdata;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h (t=%0t)", tag, act, exp, $time);
    end
  endtask

  // Per-clock comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (cmp_on) begin
      chk(tx_valid == (m_state == 1), "R3 tx_valid", 64'(tx_valid), 64'(m_state == 1));
      if (m_state == 1) begin
        chk(tx_data == byte_at(m_sel, m_idx), "R3 tx_data", 64'(tx_data), 64'(byte_at(m_sel, m_idx)));
        chk(tx_last == (m_idx == m_L - 1), "R4 tx_last", 64'(tx_last), 64'(m_idx == m_L - 1));
      end else chk(!tx_last, "R4 tx_last idle", 64'(tx_last), 64'(0));
      chk(irq == m_irq, "R9 irq", 64'(irq), 64'(m_irq));
      chk(station_addr == m_station, "R5 station", 64'(station_addr), 64'(m_station));
      chk(bus_rdata == m_rdata, "R2 rdata", 64'(bus_rdata), 64'(m_rdata));
    end
  end

  always @(posedge clk) begin
    if (cyc == 150000) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // Tasks start and end just after a falling edge
  task automatic wr(input logic [9:0] a, input logic [31:0] d);
    bus_en = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 0; bus_we = 0;
  endtask
  task automatic rd(input logic [9:0] a, output logic [31:0] v);
    bus_en = 1; bus_we = 0; bus_addr = a;
    @(negedge clk);
    bus_en = 0;
    v = bus_rdata;
  endtask
  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask
  function automatic logic [31:0] pat(int i, int s);
    return (32'(i) * 32'h01030507) ^ (32'(s) * 32'h9E3779B1);
  endfunction
  task automatic fill(input int b, input int n, input int s);
    for (int i = 0; i < n; i++) wr(10'(b*512 + i), pat(i, s));
  endtask
  task automatic drain(input bit jitter);
    int lf = 32'h5A5A1;
    for (int k = 0; k < 6000; k++) begin
      if (!(m_state == 1 || m_ctrl[0][0] || m_ctrl[1][0])) break;
      lf = (lf >> 1) ^ ((lf & 1) ? 32'hB4BCD35C : 0);
      tx_ready = jitter ? lf[3] : 1'b1;
      @(negedge clk);
    end
    tx_ready = 0;
    idle(2);
  endtask
  task automatic to_last_byte();
    for (int k = 0; k < 100; k++) begin
      if (m_state == 1 && m_idx == m_L - 1) break;
      tx_ready = 1;
      @(negedge clk);
    end
    tx_ready = 0;
    idle(2);
  endtask

  initial begin
    logic [31:0] v;
    int h0, i0;
    idle(4);
    rst_n = 1;
    @(negedge clk);
    cmp_on = 1;
    // R1: reset state
    chk(!tx_valid && !tx_last && !irq, "R1 outputs idle", {tx_valid, tx_last, irq}, 0);
    chk(station_addr == 48'h0, "R1 station", station_addr, 0);
    rd(10'd511, v); chk(v == 0, "R1 ctrl0", v, 0);
    rd(10'd1021, v); chk(v == 0, "R1 len1", v, 0);
    rd(10'd510, v); chk(v == 0, "R1 gie", v, 0);

    // R2: decode and read-back
    fill(0, 4, 1);
    wr(10'd509, 32'd7);
    rd(10'd509, v); chk(v == 7, "R2 len0 readback", v, 7);
    rd(10'd2, v); chk(v == pat(2, 1), "R2 data readback", v, pat(2, 1));

    // R3/R6/R7/R9: send with jittered ready
    wr(10'd510, 32'h8000_0000);
    h0 = n_hs; i0 = n_irq;
    wr(10'd511, 32'h9);
    rd(10'd511, v); chk(v == 32'h9, "R6 busy readback", v, 32'h9);
    chk(tx_valid && tx_data == pat(0, 1) >> 24, "R3 first byte", tx_data, pat(0, 1) >> 24);
    wr(10'd511, 32'h0);
    rd(10'd511, v); chk(v == 32'h9, "R7 busy write ignored", v, 32'h9);
    drain(1);
    rd(10'd511, v); chk(v == 32'h8, "R6 cleared on completion", v, 32'h8);
    chk(n_hs - h0 == 7, "R3 byte count", n_hs - h0, 7);
    chk(n_irq - i0 == 1, "R9 one pulse", n_irq - i0, 1);

    // R5: program station address
    wr(10'd512, 32'h1122_3344);
    wr(10'd513, 32'h5566_7788);
    h0 = n_hs;
    wr(10'd1023, 32'hB);
    idle(3);
    chk(station_addr == 48'h1122_3344_5566, "R5 station loaded", station_addr, 48'h1122_3344_5566);
    chk(n_hs == h0, "R5 nothing sent", n_hs - h0, 0);
    rd(10'd1023, v); chk(v == 32'h8, "R6 program cleared", v, 32'h8);

    // Collision: buffer 0 finishes as buffer 1 is started
    wr(10'd509, 32'd5); wr(10'd1021, 32'd3);
    h0 = n_hs; i0 = n_irq;
    wr(10'd511, 32'h9);
    to_last_byte();
    tx_ready = 1;
    wr(10'd1023, 32'h9);
    drain(0);
    chk(n_hs - h0 == 8, "R3 back-to-back bytes", n_hs - h0, 8);
    chk(n_irq - i0 == 2, "R9 two completions", n_irq - i0, 2);

    // Collision: command write to buffer 0 in its own completion clock
    h0 = n_hs;
    wr(10'd511, 32'h9);
    to_last_byte();
    tx_ready = 1;
    wr(10'd511, 32'h1);
    drain(0);
    rd(10'd511, v); chk(v == 32'h8, "R7 write at completion ignored", v, 32'h8);
    chk(n_hs - h0 == 5, "R7 no second frame", n_hs - h0, 5);

    // R8: zero length
    wr(10'd1021, 32'd0);
    h0 = n_hs; i0 = n_irq;
    wr(10'd1023, 32'h9);
    drain(0);
    chk(n_hs == h0, "R8 zero length silent", n_hs - h0, 0);
    chk(n_irq - i0 == 1, "R9 zero length irq", n_irq - i0, 1);

    // R9: global enable off
    wr(10'd510, 32'h7FFF_FFFF);
    wr(10'd1021, 32'd3);
    i0 = n_irq;
    wr(10'd1023, 32'h9);
    drain(1);
    chk(n_irq == i0, "R9 gated by global enable", n_irq - i0, 0);

    // R10: write without start
    h0 = n_hs;
    wr(10'd511, 32'hA);
    rd(10'd511, v); chk(v == 32'h8, "R10 no start stored", v, 32'h8);
    idle(4);
    chk(n_hs == h0 && !tx_valid, "R10 nothing sent", n_hs - h0, 0);

    // R8: clamp to 2036 bytes
    fill(0, 509, 7);
    wr(10'd509, 32'd3000);
    h0 = n_hs;
    wr(10'd511, 32'h1);
    drain(0);
    chk(n_hs - h0 == 2036, "R8 clamped length", n_hs - h0, 2036);

    cmp_on = 0;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule